// File: doc/BRIEF.md
# Double-Buffered Bridge PWM Generator

This block produces a pulse-width-modulated waveform from an 8-bit period timer and a 10-bit duty value. The duty value is split into an 8-bit high part and a 2-bit low part. The low part resolves a quarter of a timer step, using a 2-bit sub-count taken from the clock prescaler phase. The timer counts from zero up to the programmed period and then wraps. The output goes high at each wrap and goes low once the duty position has been reached.

Software writes the period, both duty parts, the prescale choice and the output mode through a simple write port. The duty parts, the prescale choice and the mode are held in shadow state and take effect only when a period completes, so a write never produces a torn pulse. The PWM signal is steered to four pins, named A to D. The available configurations are a single output, a complementary half-bridge pair, and a full bridge driven forward or in reverse.

Top module: `epwm_gen`

## Requirements
- R1: A write is accepted on a rising clock edge when `wr_en` is high, with `wr_sel` choosing the target: 0 period, 1 duty high (8 bits), 2 duty low (`wr_data[1:0]`), 3 prescale (`wr_data[1:0]`), 4 mode (`wr_data[1:0]`). Select codes 5, 6 and 7 change nothing.
- R2: One PWM period lasts 4·div·(period+1) clocks. The divider div is 1 for prescale code 0, 4 for code 1, and 16 for codes 2 and 3.
- R3: With the duty D = high·4 + low and 1 ≤ D < 4·(period+1), the PWM signal is high for exactly D·div clocks of each period. It rises at the period boundary.
- R4: With D = 0, the PWM signal stays low for the whole period.
- R5: With D ≥ 4·(period+1), the PWM signal is never cleared and stays high for every clock.
- R6: A duty write made during a period leaves that period's pulse unchanged. The new value applies from the next period boundary.
- R7: A mode write leaves the pins unchanged until the next period boundary.
- R8: Mode 0 (single): pin A carries the PWM signal and B, C, D are low.
- R9: Mode 1 (half-bridge): pin A carries the PWM signal, B carries its complement, and C, D are low.
- R10: Mode 2 (full-bridge forward): A is held high, D carries the PWM signal, and B, C are low.
- R11: Mode 3 (full-bridge reverse): C is held high, B carries the PWM signal, and A, D are low.
- R12: Driving `rst_n` low forces all four pins low at once. After release the pins stay low, with duty 0, period 255, divide-by-1 and single mode in force.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write target select |
| wr_data | input | 8 | Write data |
| pwm_out | output | 4 | Steered outputs, bit 0 = A, 1 = B, 2 = C, 3 = D |

## Verification
A write lands on the next clock edge. Shadowed settings, however, appear only after the next period boundary, and the first boundary after reset can be up to 1028 clocks away. Each table vector therefore waits 1100 clocks before it measures. It then counts high samples and rising edges over exactly three periods, which is independent of phase. Samples are taken on the falling edge. Pulse widths for the double-buffering and mode-deferral tests are read one falling edge after the observed fall, so the monitor's update has settled before the check.

// File: rtl/epwm_pkg.sv
package epwm_pkg;
  localparam int PS_W  = 4;  // log2 of the largest prescale division
  localparam int OUT_N = 4;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_HALF   = 2'd1,
    MODE_FWD    = 2'd2,
    MODE_REV    = 2'd3
  } epwm_mode_e;

  typedef enum logic [2:0] {
    SEL_PERIOD   = 3'd0,
    SEL_DUTY_HI  = 3'd1,
    SEL_DUTY_LO  = 3'd2,
    SEL_PRESCALE = 3'd3,
    SEL_MODE     = 3'd4
  } epwm_sel_e;
endpackage

// File: rtl/epwm_regs.sv
module epwm_regs
  import epwm_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FRAC_W = 2,
  localparam int DUTY_W = TMR_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [TMR_W-1:0]  wr_data,
  output logic [TMR_W-1:0]  period_o,
  output logic [DUTY_W-1:0] duty_o,
  output logic [1:0]        ps_o,
  output epwm_mode_e        mode_o
);
  logic [TMR_W-1:0]  period_q, period_n;
  logic [TMR_W-1:0]  dhi_q, dhi_n;
  logic [FRAC_W-1:0] dlo_q, dlo_n;
  logic [1:0]        ps_q, ps_n;
  epwm_mode_e        mode_q, mode_n;

  always_comb begin
    period_n = period_q;
    dhi_n    = dhi_q;
    dlo_n    = dlo_q;
    ps_n     = ps_q;
    mode_n   = mode_q;
    if (wr_en) begin
      if (wr_sel == SEL_PERIOD)   period_n = wr_data;
      if (wr_sel == SEL_DUTY_HI)  dhi_n    = wr_data;
      if (wr_sel == SEL_DUTY_LO)  dlo_n    = wr_data[FRAC_W-1:0];
      if (wr_sel == SEL_PRESCALE) ps_n     = wr_data[1:0];
      if (wr_sel == SEL_MODE)     mode_n   = epwm_mode_e'(wr_data[1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '1;
      dhi_q    <= '0;
      dlo_q    <= '0;
      ps_q     <= '0;
      mode_q   <= MODE_SINGLE;
    end else begin
      period_q <= period_n;
      dhi_q    <= dhi_n;
      dlo_q    <= dlo_n;
      ps_q     <= ps_n;
      mode_q   <= mode_n;
    end
  end

  assign period_o = period_q;
  assign duty_o   = {dhi_q, dlo_q};
  assign ps_o     = ps_q;
  assign mode_o   = mode_q;
endmodule

// File: rtl/epwm_timebase.sv
module epwm_timebase
  import epwm_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FRAC_W = 2,
  localparam int CNT_W = FRAC_W + PS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TMR_W-1:0]  period_i,
  input  logic [1:0]        ps_sel_i,
  output logic [TMR_W-1:0]  tmr_o,
  output logic [FRAC_W-1:0] sub_o,
  output logic              step_o,
  output logic              prd_end_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [TMR_W-1:0] tmr_q, tmr_n;
  logic [1:0]       ps_q, ps_n;
  logic [1:0]       ps_eff;
  logic [2:0]       shift;
  logic [CNT_W-1:0] low_mask;
  logic             step, tick, prd_end;

  // Division 1, 4, 16: the prescaler phase below the sub-count is 0, 2 or 4 bits wide.
  always_comb begin
    ps_eff   = ps_q[1] ? 2'd2 : ps_q;
    shift    = {ps_eff, 1'b0};
    low_mask = (CNT_W'(1) << shift) - CNT_W'(1);
    step     = (cnt_q & low_mask) == low_mask;
    sub_o    = FRAC_W'(cnt_q >> shift);
    tick     = step && (sub_o == {FRAC_W{1'b1}});
    prd_end  = tick && (tmr_q == period_i);
  end

  always_comb begin
    cnt_n = tick ? '0 : cnt_q + CNT_W'(1);
    tmr_n = tmr_q;
    if (tick) tmr_n = prd_end ? '0 : tmr_q + TMR_W'(1);
    ps_n  = prd_end ? ps_sel_i : ps_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tmr_q <= '0;
      ps_q  <= '0;
    end else begin
      cnt_q <= cnt_n;
      tmr_q <= tmr_n;
      ps_q  <= ps_n;
    end
  end

  assign tmr_o     = tmr_q;
  assign step_o    = step;
  assign prd_end_o = prd_end;
endmodule

// File: rtl/epwm_shadow.sv
module epwm_shadow
  import epwm_pkg::*;
#(
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prd_end_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  epwm_mode_e        mode_i,
  output logic [DUTY_W-1:0] duty_o,
  output epwm_mode_e        mode_o
);
  logic [DUTY_W-1:0] duty_q, duty_n;
  epwm_mode_e        mode_q, mode_n;

  always_comb begin
    duty_n = prd_end_i ? duty_i : duty_q;
    mode_n = prd_end_i ? mode_i : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
      mode_q <= MODE_SINGLE;
    end else begin
      duty_q <= duty_n;
      mode_q <= mode_n;
    end
  end

  assign duty_o = duty_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/epwm_wave.sv
module epwm_wave #(
  parameter int TMR_W  = 8,
  parameter int FRAC_W = 2,
  localparam int DUTY_W = TMR_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prd_end_i,
  input  logic              step_i,
  input  logic [TMR_W-1:0]  tmr_i,
  input  logic [FRAC_W-1:0] sub_i,
  input  logic [DUTY_W-1:0] duty_act_i,
  input  logic [DUTY_W-1:0] duty_nxt_i,
  output logic              pwm_o
);
  logic [DUTY_W:0] pos_next;
  logic            clear, pwm_q, pwm_n;

  // Clear at the end of the sub-step whose following position equals the duty.
  always_comb begin
    pos_next = {1'b0, tmr_i, sub_i} + (DUTY_W+1)'(1);
    clear    = step_i && (pos_next == {1'b0, duty_act_i});
    pwm_n    = pwm_q;
    if (clear)     pwm_n = 1'b0;
    if (prd_end_i) pwm_n = (duty_nxt_i != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= pwm_n;
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/epwm_steer.sv
module epwm_steer
  import epwm_pkg::*;
(
  input  epwm_mode_e       mode_i,
  input  logic             pwm_i,
  output logic [OUT_N-1:0] out_o
);
  always_comb begin
    out_o = '0;
    case (mode_i)
      MODE_SINGLE: out_o[0] = pwm_i;
      MODE_HALF: begin
        out_o[0] = pwm_i;
        out_o[1] = ~pwm_i;
      end
      MODE_FWD: begin
        out_o[0] = 1'b1;
        out_o[3] = pwm_i;
      end
      MODE_REV: begin
        out_o[2] = 1'b1;
        out_o[1] = pwm_i;
      end
      default: out_o = '0;
    endcase
  end
endmodule

// File: rtl/epwm_gen.sv
module epwm_gen
  import epwm_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int FRAC_W = 2,
  localparam int DUTY_W = TMR_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_sel,
  input  logic [TMR_W-1:0] wr_data,
  output logic [OUT_N-1:0] pwm_out
);
  logic [1:0]        rst_sync_q;
  logic              rst_i_n;
  logic [TMR_W-1:0]  period;
  logic [DUTY_W-1:0] duty_w, duty_act;
  logic [1:0]        ps_sel;
  epwm_mode_e        mode_w, mode_act;
  logic [TMR_W-1:0]  tmr;
  logic [FRAC_W-1:0] sub;
  logic              step, prd_end, pwm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  epwm_regs #(.TMR_W(TMR_W), .FRAC_W(FRAC_W)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .period_o(period), .duty_o(duty_w), .ps_o(ps_sel), .mode_o(mode_w)
  );

  epwm_timebase #(.TMR_W(TMR_W), .FRAC_W(FRAC_W)) u_tb (
    .clk(clk), .rst_n(rst_i_n), .period_i(period), .ps_sel_i(ps_sel),
    .tmr_o(tmr), .sub_o(sub), .step_o(step), .prd_end_o(prd_end)
  );

  epwm_shadow #(.DUTY_W(DUTY_W)) u_shadow (
    .clk(clk), .rst_n(rst_i_n), .prd_end_i(prd_end), .duty_i(duty_w),
    .mode_i(mode_w), .duty_o(duty_act), .mode_o(mode_act)
  );

  epwm_wave #(.TMR_W(TMR_W), .FRAC_W(FRAC_W)) u_wave (
    .clk(clk), .rst_n(rst_i_n), .prd_end_i(prd_end), .step_i(step),
    .tmr_i(tmr), .sub_i(sub), .duty_act_i(duty_act), .duty_nxt_i(duty_w),
    .pwm_o(pwm)
  );

  epwm_steer u_steer (.mode_i(mode_act), .pwm_i(pwm), .out_o(pwm_out));
endmodule

// File: rtl/epwm_chk.sv
module epwm_chk
  import epwm_pkg::*;
#(
  parameter int DUTY_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prd_end,
  input logic [DUTY_W-1:0] duty_w,
  input logic [DUTY_W-1:0] duty_act,
  input epwm_mode_e        mode_act,
  input logic              pwm,
  input logic [OUT_N-1:0]  pwm_out
);
  assert_duty_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !prd_end |=> $stable(duty_act));
  assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !prd_end |=> $stable(mode_act));
  assert_zero_duty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_end && duty_w == '0) |=> !pwm);
  assert_set_at_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_end && duty_w != '0) |=> pwm);
  assert_rise_at_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm) |-> $past(prd_end));
  assert_half_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == MODE_HALF) |-> (pwm_out[1] != pwm_out[0]));
  assert_fwd_pins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == MODE_FWD) |-> (pwm_out[0] && pwm_out[2:1] == 2'b00));
  assert_rev_pins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_act == MODE_REV) |-> (pwm_out[2] && !pwm_out[0] && !pwm_out[3]));
endmodule

bind epwm_gen epwm_chk u_chk (
  .clk(clk), .rst_n(rst_i_n), .prd_end(prd_end), .duty_w(duty_w),
  .duty_act(duty_act), .mode_act(mode_act), .pwm(pwm), .pwm_out(pwm_out)
);

// File: tb/sim_epwm_gen.sv
module sim_epwm_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_sel;
  logic [7:0] wr_data;
  logic [3:0] pwm_out;
  int         n_chk = 0;
  int         n_bad = 0;
  int         cur_run = 0;
  int         last_run = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  epwm_gen u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
               .wr_data(wr_data), .pwm_out(pwm_out));

  // Fields: period, duty hi, duty lo, prescale, mode, high clocks, period clocks
  localparam int NV = 12;
  localparam logic [71:0] VEC [NV] = '{
    {8'd9, 8'd2, 8'd1, 8'd0, 8'd0, 16'd9,  16'd40},
    {8'd9, 8'd5, 8'd0, 8'd0, 8'd1, 16'd20, 16'd40},
    {8'd4, 8'd1, 8'd3, 8'd0, 8'd2, 16'd7,  16'd20},
    {8'd4, 8'd3, 8'd2, 8'd0, 8'd3, 16'd14, 16'd20},
    {8'd3, 8'd1, 8'd2, 8'd1, 8'd0, 16'd24, 16'd64},
    {8'd2, 8'd1, 8'd1, 8'd2, 8'd1, 16'd80, 16'd192},
    {8'd5, 8'd0, 8'd0, 8'd0, 8'd0, 16'd0,  16'd24},
    {8'd5, 8'd6, 8'd0, 8'd0, 8'd0, 16'd24, 16'd24},
    {8'd5, 8'd7, 8'd0, 8'd0, 8'd2, 16'd24, 16'd24},
    {8'd5, 8'd5, 8'd3, 8'd0, 8'd0, 16'd23, 16'd24},
    {8'd0, 8'd0, 8'd1, 8'd0, 8'd3, 16'd1,  16'd4},
    {8'd1, 8'd0, 8'd3, 8'd3, 8'd0, 16'd48, 16'd128}
  };

  always @(negedge clk) begin
    if (pwm_out[0]) cur_run <= cur_run + 1;
    else begin
      if (cur_run != 0) last_run <= cur_run;
      cur_run <= 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] data);
    wr_sel = sel; wr_data = data; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_rise();
    logic p;
    p = pwm_out[0];
    forever begin
      @(negedge clk);
      if (pwm_out[0] && !p) break;
      p = pwm_out[0];
    end
  endtask

  task automatic wait_fall();
    while (pwm_out[0]) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic string mode_tag(input int m);
    case (m)
      0: return "R8";
      1: return "R9";
      2: return "R10";
      default: return "R11";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R12: reset state
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk("R12 pins in reset", int'(pwm_out), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R12 pins after release", int'(pwm_out), 0);

    for (int v = 0; v < NV; v++) begin
      int pr, dh, dl, ps, md, eh, ep, idx, hi, rises, bad_const, d;
      logic prev, o;
      pr = int'(VEC[v][71:64]); dh = int'(VEC[v][63:56]); dl = int'(VEC[v][55:48]);
      ps = int'(VEC[v][47:40]); md = int'(VEC[v][39:32]);
      eh = int'(VEC[v][31:16]); ep = int'(VEC[v][15:0]);
      d  = dh * 4 + dl;
      idx = (md == 2) ? 3 : (md == 3) ? 1 : 0;
      do_reset();
      wr(3'd0, 8'(pr)); wr(3'd1, 8'(dh)); wr(3'd2, 8'(dl));
      wr(3'd3, 8'(ps)); wr(3'd4, 8'(md));
      repeat (1100) @(negedge clk);
      hi = 0; rises = 0; bad_const = 0;
      prev = pwm_out[idx];
      for (int k = 0; k < 3 * ep; k++) begin
        @(negedge clk);
        o = pwm_out[idx];
        if (o) hi++;
        if (o && !prev) rises++;
        prev = o;
        case (md)
          0: if (pwm_out[3:1] != 3'b000) bad_const++;
          1: if (pwm_out[1] == pwm_out[0] || pwm_out[3:2] != 2'b00) bad_const++;
          2: if (!pwm_out[0] || pwm_out[2:1] != 2'b00) bad_const++;
          default: if (!pwm_out[2] || pwm_out[0] || pwm_out[3]) bad_const++;
        endcase
      end
      if (d == 0)       chk("R4 high clocks", hi, 0);
      else if (eh == ep) chk("R5 high clocks", hi, 3 * ep);
      else              chk("R3 high clocks", hi, 3 * eh);
      chk("R2 rising edges per 3 periods", rises, (eh > 0 && eh < ep) ? 3 : 0);
      chk({mode_tag(md), " pin pattern"}, bad_const, 0);
    end

    // R6: duty written mid-period applies from the next period
    do_reset();
    wr(3'd0, 8'd9); wr(3'd1, 8'd2); wr(3'd2, 8'd1);
    repeat (1100) @(negedge clk);
    wait_rise();
    wr(3'd1, 8'd7); wr(3'd2, 8'd2);
    wait_fall();
    chk("R6 current pulse keeps old duty", last_run, 9);
    wait_rise(); wait_fall();
    chk("R6 next pulse uses new duty", last_run, 30);

    // R1: unused select codes change nothing
    wr(3'd5, 8'd0); wr(3'd6, 8'd0); wr(3'd7, 8'd0);
    wait_rise(); wait_fall();
    chk("R1 unused selects ignored", last_run, 30);

    // R7: mode change deferred to the boundary
    wait_rise();
    wr(3'd4, 8'd2);
    repeat (2) @(negedge clk);
    chk("R7 pins unchanged before boundary", int'(pwm_out), 1);
    repeat (50) @(negedge clk);
    chk("R10 forward applied after boundary", int'({pwm_out[2:0]}), 1);

    // R12: asynchronous reset mid-operation
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R12 async clear", int'(pwm_out), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    chk("R12 low after release", int'(pwm_out), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule